// File: doc/BRIEF.md
# Credit-Based Transmit Shaper Arbiter

This block chooses which traffic class may send the next frame on a shared transmit link. There are two classes: a time-sensitive audio/video (AV) class and a best-effort (BE) class. The arbiter keeps a signed credit count for the AV class. While an AV frame is on the wire, the credit falls at a programmable send slope. While the AV class is waiting, or while its credit is still negative, the credit rises at a programmable idle slope. The ratio of the two slopes caps the share of link time that AV frames can take. With the reset values, that cap is 75%.

Each class raises a ready flag when it holds a frame. The arbiter answers with a grant that stays high for the whole frame. The transmit side pulses `frame_done` during the last cycle of the frame. BE frames fill every gap in which AV is not allowed to send, so the link does not idle while either class has data. The two slope values are written and read through a small word-addressed register port.

Top module: `cbs_tx_arbiter`

## Requirements
- R1: After reset, both grants are low, the send slope reads 2048 and the idle slope reads 6144.
- R2: The register port has two 20-bit slope fields, each in data bits 19:0. Address 0 is the send slope and address 1 is the idle slope. Write bits 31:20 are dropped and read back as zero. Any other address reads zero, and writes to it change nothing.
- R3: The credit falls by the send slope on every clock edge where an AV frame is granted, including the edge that ends the frame.
- R4: On every edge where no AV frame is granted and the AV queue is ready, the credit rises by the idle slope. It saturates at its most positive value.
- R5: A new grant is decided only in an arbitration cycle, when neither grant is high. AV wins if `av_ready` is high and the credit is zero or positive. The grant appears one clock later.
- R6: A grant stays high until `frame_done` is seen high while it is held. The next cycle is always an arbitration cycle with both grants low. A class that becomes eligible mid-frame does not preempt the frame.
- R7: In an arbitration cycle, if `be_ready` is high and AV is not eligible, BE is granted on the next clock. The two grants are never high together.
- R8: When the AV queue is not ready and no AV frame is granted, positive credit is cleared to zero. Negative credit keeps rising by the idle slope, but only up to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| av_ready | input | 1 | AV queue holds a frame |
| be_ready | input | 1 | BE queue holds a frame |
| frame_done | input | 1 | Last cycle of the frame now being sent |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (2) | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| grant_av | output | 1 | AV frame in progress |
| grant_be | output | 1 | BE frame in progress |

## Verification
The hardest case to reach from the ports is the discard of positive credit. AV has to wait behind a long BE frame and gather credit, and then its queue has to empty before that BE frame ends. The stimulus holds a BE frame open, raises `av_ready` for several cycles, drops it, and only then ends the BE frame. The credit itself is never visible at the ports. So its value is read from the number of arbitration cycles after the next AV frame of known length, which is 12 cycles if the credit was cleared and much shorter if it was kept. The same gap count is used to check that negative credit recovers while AV is absent and stops at zero.

// File: rtl/cbs_pkg.sv
// Package: shared constants and types for the credit-based shaper arbiter.
// Assumes: a 32-bit register data path, and that slope fields start at bit 0.
package cbs_pkg;

    localparam int CFG_DATA_W = 32;
    localparam int SLOPE_BITS = 20;

    // Word indices of the two slope registers
    localparam int SEND_IDX = 0;
    localparam int IDLE_IDX = 1;
    localparam int NUM_SLOPES = 2;

    // Reset values; idle/(idle+send) = 6144/8192 gives a 75% AV cap
    localparam logic [SLOPE_BITS-1:0] SEND_RESET = SLOPE_BITS'(2048);
    localparam logic [SLOPE_BITS-1:0] IDLE_RESET = SLOPE_BITS'(6144);

    typedef enum logic [1:0] {
        ARB_PICK = 2'd0,
        ARB_AV   = 2'd1,
        ARB_BE   = 2'd2
    } arb_state_t;

endpackage

// File: rtl/cbs_slope_regs.sv
// Module: slope register file. Holds the send and idle slope fields.
// Assumes: single-cycle writes; reads are combinational on the address.
module cbs_slope_regs
    import cbs_pkg::*;
#(
    parameter int SLOPE_W = SLOPE_BITS,
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = CFG_DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [SLOPE_W-1:0] send_slope,
    output logic [SLOPE_W-1:0] idle_slope
);

    localparam int PAD_W = DATA_W - SLOPE_W;

    logic [SLOPE_W-1:0] slope_q [NUM_SLOPES];

    for (genvar gi = 0; gi < NUM_SLOPES; gi++) begin : g_slope
        localparam logic [SLOPE_W-1:0] RST_V =
            (gi == SEND_IDX) ? SLOPE_W'(SEND_RESET) : SLOPE_W'(IDLE_RESET);

        // Load one slope field on a matching write; upper data bits are dropped
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slope_q[gi] <= RST_V;
            end else if (we && (addr == ADDR_W'(gi))) begin
                slope_q[gi] <= wdata[SLOPE_W-1:0];
            end
        end
    end

    // Read mux: zero-extended field, zero for unmapped addresses
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SLOPES; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = {{PAD_W{1'b0}}, slope_q[i]};
            end
        end
    end

    assign send_slope = slope_q[SEND_IDX];
    assign idle_slope = slope_q[IDLE_IDX];

endmodule

// File: rtl/cbs_credit.sv
// Module: signed credit accumulator for the AV class.
// Assumes: CRED_W is wide enough that one maximum-length AV frame at the
// largest send slope cannot wrap the negative side. The positive side saturates.
module cbs_credit #(
    parameter int SLOPE_W = 20,
    parameter int CRED_W  = 36
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     av_active,
    input  logic                     av_ready,
    input  logic [SLOPE_W-1:0]       send_slope,
    input  logic [SLOPE_W-1:0]       idle_slope,
    output logic signed [CRED_W-1:0] credit,
    output logic                     credit_ok
);

    localparam int XW    = CRED_W + 1;
    localparam int EXT_W = XW - SLOPE_W;
    localparam logic signed [XW-1:0] CMAX_X = {2'b00, {(CRED_W-1){1'b1}}};
    localparam logic signed [CRED_W-1:0] CMAX = {1'b0, {(CRED_W-1){1'b1}}};

    logic signed [CRED_W-1:0] credit_q;
    logic signed [CRED_W-1:0] credit_d;
    logic signed [XW-1:0]     cred_x;
    logic signed [XW-1:0]     idle_x;
    logic signed [XW-1:0]     send_x;
    logic signed [XW-1:0]     up_x;
    logic signed [XW-1:0]     down_x;

    // Widen operands by one bit so the sums cannot wrap
    always_comb begin
        cred_x = {credit_q[CRED_W-1], credit_q};
        idle_x = signed'({{EXT_W{1'b0}}, idle_slope});
        send_x = signed'({{EXT_W{1'b0}}, send_slope});
        up_x   = cred_x + idle_x;
        down_x = cred_x - send_x;
    end

    // Next credit: drain while sending, gain while waiting, settle toward zero when idle
    always_comb begin
        if (av_active) begin
            credit_d = down_x[CRED_W-1:0];
        end else if (av_ready) begin
            credit_d = (up_x > CMAX_X) ? CMAX : up_x[CRED_W-1:0];
        end else if (credit_q < 0) begin
            credit_d = (up_x > 0) ? '0 : up_x[CRED_W-1:0];
        end else begin
            credit_d = '0;
        end
    end

    // Credit register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_q <= '0;
        end else begin
            credit_q <= credit_d;
        end
    end

    assign credit    = credit_q;
    assign credit_ok = !credit_q[CRED_W-1];

endmodule

// File: rtl/cbs_grant_fsm.sv
// Module: non-preemptive frame grant state machine.
// Assumes: frame_done is pulsed during the last cycle of a granted frame.
// Every grant is followed by one arbitration cycle with no grant.
module cbs_grant_fsm
    import cbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic av_ready,
    input  logic be_ready,
    input  logic frame_done,
    input  logic credit_ok,
    output logic grant_av,
    output logic grant_be
);

    arb_state_t state_q;
    arb_state_t state_d;

    // Next state: AV first when eligible, BE fills otherwise, hold until done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_PICK: begin
                if (av_ready && credit_ok) begin
                    state_d = ARB_AV;
                end else if (be_ready) begin
                    state_d = ARB_BE;
                end
            end
            ARB_AV, ARB_BE: begin
                if (frame_done) begin
                    state_d = ARB_PICK;
                end
            end
            default: state_d = ARB_PICK;
        endcase
    end

    // State register, returns to arbitration on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_PICK;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant_av = (state_q == ARB_AV);
    assign grant_be = (state_q == ARB_BE);

endmodule

// File: rtl/cbs_tx_arbiter.sv
// Module: credit-based transmit shaper arbiter (top).
// Assumes: no frame longer than MAX_FRAME cycles; ready flags are level signals.
module cbs_tx_arbiter
    import cbs_pkg::*;
#(
    parameter int SLOPE_W   = SLOPE_BITS,
    parameter int ADDR_W    = 2,
    parameter int MAX_FRAME = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              av_ready,
    input  logic              be_ready,
    input  logic              frame_done,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              grant_av,
    output logic              grant_be
);

    localparam int CRED_W = SLOPE_W + $clog2(MAX_FRAME) + 2;

    logic [SLOPE_W-1:0]       send_slope;
    logic [SLOPE_W-1:0]       idle_slope;
    logic signed [CRED_W-1:0] credit_q;
    logic                     credit_ok;

    cbs_slope_regs #(
        .SLOPE_W (SLOPE_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (32)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .send_slope (send_slope),
        .idle_slope (idle_slope)
    );

    cbs_credit #(
        .SLOPE_W (SLOPE_W),
        .CRED_W  (CRED_W)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .av_active  (grant_av),
        .av_ready   (av_ready),
        .send_slope (send_slope),
        .idle_slope (idle_slope),
        .credit     (credit_q),
        .credit_ok  (credit_ok)
    );

    cbs_grant_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .av_ready   (av_ready),
        .be_ready   (be_ready),
        .frame_done (frame_done),
        .credit_ok  (credit_ok),
        .grant_av   (grant_av),
        .grant_be   (grant_be)
    );

endmodule

// File: rtl/cbs_tx_arbiter_chk.sv
// Module: property checker for cbs_tx_arbiter, attached by bind below.
// Assumes: it observes the top's ports plus the internal credit and slopes.
module cbs_tx_arbiter_chk #(
    parameter int SLOPE_W = 20,
    parameter int CRED_W  = 36
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     av_ready,
    input logic                     be_ready,
    input logic                     frame_done,
    input logic                     grant_av,
    input logic                     grant_be,
    input logic signed [CRED_W-1:0] credit,
    input logic [SLOPE_W-1:0]       send_slope,
    input logic [SLOPE_W-1:0]       idle_slope,
    input logic [31:0]              cfg_rdata
);

    logic signed [CRED_W-1:0] send_x;
    logic signed [CRED_W-1:0] idle_x;
    logic                     picking;

    assign send_x  = signed'({{(CRED_W-SLOPE_W){1'b0}}, send_slope});
    assign idle_x  = signed'({{(CRED_W-SLOPE_W){1'b0}}, idle_slope});
    assign picking = !grant_av && !grant_be;

    p_regs_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:20] == 12'h000);

    p_send_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_av |=> (credit == $past(credit) - $past(send_x)));

    p_idle_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_av && av_ready && credit <= 0) |=> (credit == $past(credit) + $past(idle_x)));

    p_av_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (picking && av_ready && credit >= 0) |=> grant_av);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_av || grant_be) && !frame_done) |=> $stable({grant_av, grant_be}));

    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_av || grant_be) && frame_done) |=> picking);

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_av, grant_be}));

    p_be_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (picking && be_ready && !(av_ready && credit >= 0)) |=> grant_be);

    p_empty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_av && !av_ready && credit >= 0) |=> (credit == 0));

    p_neg_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_av && !av_ready) |=> (credit <= 0));

endmodule

bind cbs_tx_arbiter cbs_tx_arbiter_chk #(
    .SLOPE_W (SLOPE_W),
    .CRED_W  (CRED_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .av_ready   (av_ready),
    .be_ready   (be_ready),
    .frame_done (frame_done),
    .grant_av   (grant_av),
    .grant_be   (grant_be),
    .credit     (credit_q),
    .send_slope (send_slope),
    .idle_slope (idle_slope),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/cbs_tx_arbiter_tb.sv
// Bench: directed scenarios for cbs_tx_arbiter, one task each.
module cbs_tx_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        av_ready = 1'b0;
    logic        be_ready = 1'b0;
    logic        frame_done = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        grant_av;
    logic        grant_be;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cbs_tx_arbiter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .av_ready   (av_ready),
        .be_ready   (be_ready),
        .frame_done (frame_done),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .grant_av   (grant_av),
        .grant_be   (grant_be)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // Idle both queues long enough for any credit to settle at zero
    task automatic settle();
        av_ready = 1'b0; be_ready = 1'b0; frame_done = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    // Wait for the AV grant, hold it for len cycles, end with frame_done
    task automatic run_av_frame(input int len);
        int guard = 0;
        while (!grant_av && guard < 500) begin
            @(negedge clk); guard++;
        end
        for (int i = 1; i <= len; i++) begin
            if (!grant_av) chk(1'b0, "R6", "AV grant dropped mid-frame", i, len);
            if (i == len) frame_done = 1'b1;
            @(negedge clk);
        end
        frame_done = 1'b0;
    endtask

    // Count cycles with no AV grant until the next one arrives
    task automatic count_gap(output int gap);
        gap = 0;
        while (!grant_av && gap < 500) begin
            gap++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(!grant_av && !grant_be, "R1", "grants after reset", {grant_av, grant_be}, 0);
        cfg_read(2'd0, d);
        chk(d == 32'd2048, "R1", "send slope reset", d, 2048);
        cfg_read(2'd1, d);
        chk(d == 32'd6144, "R1", "idle slope reset", d, 6144);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        @(negedge clk);
        cfg_write(2'd0, 32'hFFF0_0003);
        cfg_read(2'd0, d);
        chk(d == 32'd3, "R2", "send field masked", d, 3);
        cfg_write(2'd1, 32'hABC0_0001);
        cfg_read(2'd1, d);
        chk(d == 32'd1, "R2", "idle field masked", d, 1);
        cfg_write(2'd2, 32'h000F_FFFF);
        cfg_read(2'd2, d);
        chk(d == 32'd0, "R2", "unmapped address reads zero", d, 0);
        cfg_read(2'd0, d);
        chk(d == 32'd3, "R2", "send unchanged by unmapped write", d, 3);
        cfg_read(2'd1, d);
        chk(d == 32'd1, "R2", "idle unchanged by unmapped write", d, 1);
    endtask

    // Reset slopes: 4-cycle frame ends at -2048, one recovery edge, gap 2
    task automatic t_default_slopes();
        int gap;
        cfg_write(2'd0, 32'd2048);
        cfg_write(2'd1, 32'd6144);
        av_ready = 1'b1;
        run_av_frame(4);
        count_gap(gap);
        chk(gap == 2, "R3", "gap after 4-cycle AV frame at reset slopes", gap, 2);
        run_av_frame(2);
        count_gap(gap);
        chk(gap == 1, "R4", "gap when credit stays non-negative", gap, 1);
        run_av_frame(1);
        settle();
    endtask

    // send=3, idle=1: credit 1-12=-11, so 12 arbitration cycles
    task automatic t_slow_slopes();
        int gap;
        cfg_write(2'd0, 32'd3);
        cfg_write(2'd1, 32'd1);
        av_ready = 1'b1;
        run_av_frame(4);
        count_gap(gap);
        chk(gap == 12, "R3", "gap with send 3 idle 1", gap, 12);
        run_av_frame(4);
        count_gap(gap);
        chk(gap == 12, "R4", "steady-state gap repeats", gap, 12);
        run_av_frame(1);
        settle();
        cfg_write(2'd0, 32'd1);
        av_ready = 1'b1;
        run_av_frame(3);
        count_gap(gap);
        chk(gap == 3, "R4", "gap with send 1 idle 1", gap, 3);
        run_av_frame(1);
        settle();
    endtask

    // AV has priority, then BE fills while AV recovers, BE frame not preempted
    task automatic t_be_fill();
        int av_seen = 0;
        cfg_write(2'd0, 32'd3);
        cfg_write(2'd1, 32'd1);
        av_ready = 1'b1; be_ready = 1'b1;
        @(negedge clk);
        chk(grant_av && !grant_be, "R5", "AV wins with credit zero", {grant_av, grant_be}, 2);
        run_av_frame(4);
        @(negedge clk);
        chk(grant_be && !grant_av, "R7", "BE granted while AV credit negative", {grant_av, grant_be}, 1);
        for (int i = 0; i < 20; i++) begin
            if (grant_av || !grant_be) av_seen++;
            @(negedge clk);
        end
        chk(av_seen == 0, "R6", "BE frame held without preemption", av_seen, 0);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        chk(!grant_av && !grant_be, "R6", "arbitration cycle after BE frame", {grant_av, grant_be}, 0);
        @(negedge clk);
        chk(grant_av && !grant_be, "R5", "AV granted after recovery", {grant_av, grant_be}, 2);
        run_av_frame(1);
        settle();
        be_ready = 1'b0;
        @(negedge clk);
        chk(!grant_av && !grant_be, "R7", "no grant with both queues empty", {grant_av, grant_be}, 0);
    endtask

    // Positive credit built behind a BE frame is dropped when AV empties
    task automatic t_empty_clear();
        int gap;
        cfg_write(2'd0, 32'd3);
        cfg_write(2'd1, 32'd1);
        be_ready = 1'b1;
        @(negedge clk);
        be_ready = 1'b0;
        av_ready = 1'b1;
        repeat (15) @(negedge clk);
        av_ready = 1'b0;
        repeat (3) @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        @(negedge clk);
        av_ready = 1'b1;
        run_av_frame(4);
        count_gap(gap);
        chk(gap == 12, "R8", "positive credit cleared when AV empty", gap, 12);
        run_av_frame(1);
        settle();
    endtask

    // Negative credit recovers without AV demand and stops at zero
    task automatic t_neg_recover();
        int gap;
        int more;
        cfg_write(2'd0, 32'd3);
        cfg_write(2'd1, 32'd1);
        av_ready = 1'b1;
        run_av_frame(4);
        av_ready = 1'b0;
        repeat (5) @(negedge clk);
        av_ready = 1'b1;
        count_gap(more);
        gap = 5 + more;
        chk(gap == 12, "R8", "negative credit recovers while AV absent", gap, 12);
        run_av_frame(4);
        av_ready = 1'b0;
        repeat (30) @(negedge clk);
        av_ready = 1'b1;
        @(negedge clk);
        chk(grant_av, "R5", "AV granted once recovered to zero", grant_av, 1);
        run_av_frame(4);
        count_gap(gap);
        chk(gap == 12, "R8", "recovery capped at zero", gap, 12);
        run_av_frame(1);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_default_slopes();
        t_slow_slopes();
        t_be_fill();
        t_empty_clear();
        t_neg_recover();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule